// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block keeps a nanosecond time value for precision timestamping. While enabled, each clock adds a programmable nominal step to the counter. Once every N clocks it adds a separate correction step instead, which trims the frequency without touching the reference clock. A larger correction step makes the time run faster and a smaller one makes it run slower.

The counter can wrap at a programmable period instead of at its natural width, so a period of 2^31 turns it into a 31-bit counter. Each wrap can raise a one-cycle period event. The live time value and that event go to neighbouring compare logic.

Software uses a plain word-addressed register port to do four things:
- enable counting,
- load a new time value,
- capture the running value for a later read,
- set the steps and the two periods.

Writes take effect at the clock edge where `reg_we` is high. Read data is combinational from `reg_addr`. The port has no handshake: every access completes in one cycle.

Top module: `tc_timer`

## Requirements
- R1: After reset, every readable register returns zero, `time_ns` is zero, `period_evt` is low, and the counter does not move until the enable bit (control register, address 0, bit 0) is written to 1.
- R2: While enabled, each clock adds the nominal step (address 3, bits 6:0) to the counter. While disabled, the counter holds its value.
- R3: With correction period P (address 4) nonzero, every P-th enabled clock adds the correction step (address 3, bits 14:8) in place of the nominal step. P=1 applies it on every clock, and P=0 never applies it. Writing address 4 restarts the count of clocks.
- R4: When period reset is on (address 0, bit 1) and the period register (address 2) is nonzero, a sum that reaches or exceeds the period is reduced by the period. A period of 2^31 therefore keeps the count below 2^31.
- R5: When period reset is off, or the period is zero, the counter wraps naturally modulo 2^32.
- R6: On a clock where the counter wraps, `period_evt` is high for the following cycle if the event enable (address 0, bit 7) is set. It stays low if that bit is clear.
- R7: A write to address 1 loads the written value into the counter at that edge. The load takes priority over counting and raises no event.
- R8: A control write with bit 2 set copies the counter value from before that edge into the capture register, which is read at address 1. Bit 2 always reads back as zero.
- R9: Address 0 reads back bits 0, 1 and 7. Addresses 2, 3 and 4 read back their written fields; unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| time_ns | output | 32 | Live counter value |
| period_evt | output | 1 | One-cycle pulse after a wrap |

## Verification
The live counter appears on `time_ns` on every cycle, so a wrong step choice, a misplaced wrap or a missed load shows at the very next sample. A correction counter that drifts out of phase stays hidden only until the next correction clock, at most P cycles later. A wrong capture shows on the next read of address 1. Random programming of steps, periods and loads near the wrap point is compared each cycle against a bench model, and directed cases cover P=0, P=1, both wrap modes and same-edge capture.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [2:0] {
    ADR_CTRL = 3'd0,
    ADR_TIME = 3'd1,
    ADR_PER  = 3'd2,
    ADR_INC  = 3'd3,
    ADR_CPER = 3'd4
  } tc_addr_e;

  localparam int CB_EN   = 0;
  localparam int CB_PRST = 1;
  localparam int CB_CAP  = 2;
  localparam int CB_EVT  = 7;

  localparam int NOM_LSB = 0;
  localparam int COR_LSB = 8;
endpackage

// File: rtl/tc_regs.sv
module tc_regs
  import tc_pkg::*;
#(
  parameter int W     = 32,
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      live_cnt,
  output logic              en,
  output logic              prst,
  output logic              evt_en,
  output logic [W-1:0]      per,
  output logic [STEP_W-1:0] nom,
  output logic [STEP_W-1:0] cor,
  output logic [W-1:0]      cper,
  output logic              cper_wr,
  output logic              load,
  output logic [W-1:0]      load_val,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] cap_q;
  logic         cap_req;

  assign cap_req  = we && (addr == ADR_CTRL) && wdata[CB_CAP];
  assign load     = we && (addr == ADR_TIME);
  assign load_val = wdata;
  assign cper_wr  = we && (addr == ADR_CPER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      prst   <= 1'b0;
      evt_en <= 1'b0;
      per    <= '0;
      nom    <= '0;
      cor    <= '0;
      cper   <= '0;
      cap_q  <= '0;
    end else begin
      if (cap_req) cap_q <= live_cnt;
      if (we) begin
        unique case (addr)
          ADR_CTRL: begin
            en     <= wdata[CB_EN];
            prst   <= wdata[CB_PRST];
            evt_en <= wdata[CB_EVT];
          end
          ADR_PER:  per <= wdata;
          ADR_INC: begin
            nom <= wdata[NOM_LSB +: STEP_W];
            cor <= wdata[COR_LSB +: STEP_W];
          end
          ADR_CPER: cper <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADR_CTRL: begin
        rdata[CB_EN]   = en;
        rdata[CB_PRST] = prst;
        rdata[CB_EVT]  = evt_en;
      end
      ADR_TIME: rdata = cap_q;
      ADR_PER:  rdata = per;
      ADR_INC: begin
        rdata[NOM_LSB +: STEP_W] = nom;
        rdata[COR_LSB +: STEP_W] = cor;
      end
      ADR_CPER: rdata = cper;
      default:  rdata = '0;
    endcase
  end

  // R8: capture holds the counter value from before the same edge
  p_cap_prior_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_req |=> cap_q == $past(live_cnt));
endmodule

// File: rtl/tc_corr_sched.sv
module tc_corr_sched #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         restart,
  input  logic [W-1:0] cper,
  output logic         use_corr
);
  logic [W-1:0] cc;

  assign use_corr = (cper != '0) && (cc == cper - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cc <= '0;
    else if (restart) cc <= '0;
    else if (tick)    cc <= use_corr ? '0 : cc + 1'b1;
  end

  // R3: the clock count never passes the programmed correction period
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cper != '0) |-> (cc < cper));
endmodule

// File: rtl/tc_accum.sv
module tc_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] step,
  input  logic         prst,
  input  logic [W-1:0] per,
  input  logic         evt_en,
  output logic [W-1:0] cnt,
  output logic         evt
);
  logic [W:0]   sum;
  logic [W:0]   red;
  logic         per_on;
  logic         wrap;
  logic [W-1:0] nxt;

  always_comb begin
    sum    = {1'b0, cnt} + {1'b0, step};
    per_on = prst && (per != '0);
    red    = sum - {1'b0, per};
    wrap   = per_on ? (sum >= {1'b0, per}) : sum[W];
    nxt    = (per_on && wrap) ? red[W-1:0] : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      evt <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
      evt <= 1'b0;
    end else if (tick) begin
      cnt <= nxt;
      evt <= wrap && evt_en;
    end else begin
      evt <= 1'b0;
    end
  end

  // R7: a load sets the counter to the written value
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
  // R2: with no tick and no load the counter holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));
endmodule

// File: rtl/tc_timer.sv
module tc_timer
  import tc_pkg::*;
#(
  parameter int W      = 32,
  parameter int STEP_W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [2:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic [W-1:0] time_ns,
  output logic         period_evt
);
  localparam int PADW = W - STEP_W;

  logic              en, prst, evt_en, cper_wr, load, use_corr, tick;
  logic [W-1:0]      per, cper, load_val, step;
  logic [STEP_W-1:0] nom, cor;

  tc_regs #(.W(W), .STEP_W(STEP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .live_cnt(time_ns), .en(en), .prst(prst), .evt_en(evt_en), .per(per),
    .nom(nom), .cor(cor), .cper(cper), .cper_wr(cper_wr), .load(load),
    .load_val(load_val), .rdata(reg_rdata)
  );

  assign tick = en && !load;
  assign step = use_corr ? {{PADW{1'b0}}, cor} : {{PADW{1'b0}}, nom};

  tc_corr_sched #(.W(W)) u_sched (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(cper_wr), .cper(cper),
    .use_corr(use_corr)
  );

  tc_accum #(.W(W)) u_acc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .load_val(load_val),
    .step(step), .prst(prst), .per(per), .evt_en(evt_en), .cnt(time_ns),
    .evt(period_evt)
  );

  // R6: an event only follows a clock with the event enable set
  p_evt_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |-> $past(evt_en));
  // R3: P=1 applies the correction step on every ticking clock
  p_corr_every_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cper == 1 && tick) |-> use_corr);
endmodule

// File: tb/sim_tc_timer.sv
`timescale 1ns/1ps
module sim_tc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata, time_ns;
  logic        period_evt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_cnt, m_cap, m_per, m_cp, m_cc;
  logic [6:0]  m_nom, m_cor;
  logic        m_en, m_prst, m_evten, m_evt;

  always #2.5 clk = ~clk;

  tc_timer u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
               .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_ns(time_ns),
               .period_evt(period_evt));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return {24'd0, m_evten, 5'd0, m_prst, m_en};
      3'd1: return m_cap;
      3'd2: return m_per;
      3'd3: return {17'd0, m_cor, 1'b0, m_nom};
      3'd4: return m_cp;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_step();
    logic ld, tk, uc, pon, wr;
    logic [6:0]  st;
    logic [32:0] s;
    logic [32:0] r;
    ld = reg_we && reg_addr == 3'd1;
    tk = m_en && !ld;
    if (reg_we && reg_addr == 3'd0 && reg_wdata[2]) m_cap = m_cnt;
    uc  = (m_cp != 0) && (m_cc == m_cp - 1);
    st  = uc ? m_cor : m_nom;
    s   = {1'b0, m_cnt} + {26'd0, st};
    pon = m_prst && (m_per != 0);
    wr  = pon ? (s >= {1'b0, m_per}) : s[32];
    r   = s - {1'b0, m_per};
    m_evt = 1'b0;
    if (ld) m_cnt = reg_wdata;
    else if (tk) begin
      m_cnt = (pon && wr) ? r[31:0] : s[31:0];
      m_evt = wr && m_evten;
    end
    if (reg_we && reg_addr == 3'd4) m_cc = 0;
    else if (tk) m_cc = uc ? 32'd0 : m_cc + 1;
    if (reg_we) begin
      case (reg_addr)
        3'd0: begin m_en = reg_wdata[0]; m_prst = reg_wdata[1]; m_evten = reg_wdata[7]; end
        3'd2: m_per = reg_wdata;
        3'd3: begin m_nom = reg_wdata[6:0]; m_cor = reg_wdata[14:8]; end
        3'd4: m_cp = reg_wdata;
        default: ;
      endcase
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R2 time", time_ns, m_cnt);
    chk("R6 event", {31'd0, period_evt}, {31'd0, m_evt});
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    reg_addr = a;
    #0.5;
    chk(tag, reg_rdata, model_rd(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual hang expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] t0;
    void'($urandom(32'd1234));
    m_cnt = 0; m_cap = 0; m_per = 0; m_cp = 0; m_cc = 0; m_nom = 0; m_cor = 0;
    m_en = 0; m_prst = 0; m_evten = 0; m_evt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 time", time_ns, 32'd0);
    chk("R1 event", {31'd0, period_evt}, 32'd0);
    for (int a = 0; a < 5; a++) rd("R1 reg", a[2:0]);

    // R1: no counting before enable, even with a step programmed
    wr(3'd3, 32'h0000_0305);
    repeat (3) cyc();
    chk("R1 hold", time_ns, 32'd0);

    // R9 readback of fields
    wr(3'd2, 32'h8000_0000);
    wr(3'd4, 32'd3);
    wr(3'd0, 32'hFFFF_FFFF);
    rd("R9 ctrl", 3'd0);
    chk("R9 ctrl bits", reg_rdata, 32'h0000_0083);
    rd("R9 inc", 3'd3);
    rd("R9 per", 3'd2);
    rd("R9 cper", 3'd4);

    // R3: P=1 uses correction every clock
    wr(3'd4, 32'd1);
    t0 = time_ns;
    cyc();
    chk("R3 p1", time_ns - t0, 32'd3);
    // R3: P=0 never corrects
    wr(3'd4, 32'd0);
    for (int i = 0; i < 4; i++) begin
      t0 = time_ns; cyc(); chk("R3 p0", time_ns - t0, 32'd5);
    end

    // R4: 31-bit wrap with period 2^31
    wr(3'd1, 32'h7FFF_FFFD);
    cyc();
    chk("R4 wrap", time_ns, 32'd2);
    chk("R6 pulse", {31'd0, period_evt}, 32'd1);
    cyc();
    chk("R6 one cycle", {31'd0, period_evt}, 32'd0);

    // R5: natural wrap with period reset off, event enabled
    wr(3'd0, 32'h0000_0081);
    wr(3'd1, 32'hFFFF_FFFE);
    cyc();
    chk("R5 wrap", time_ns, 32'd3);
    // R6: no event when disabled
    wr(3'd0, 32'h0000_0001);
    wr(3'd1, 32'hFFFF_FFFE);
    cyc();
    chk("R6 gated", {31'd0, period_evt}, 32'd0);

    // R7: load takes priority over counting
    wr(3'd1, 32'h1234_5678);
    chk("R7 load", time_ns, 32'h1234_5678);

    // R8: capture returns the pre-edge value
    t0 = time_ns;
    wr(3'd0, 32'h0000_0005);
    rd("R8 cap", 3'd1);
    chk("R8 prior", reg_rdata, t0);
    rd("R8 capbit", 3'd0);

    // R2: disabled counter holds
    wr(3'd0, 32'd0);
    t0 = time_ns;
    repeat (3) cyc();
    chk("R2 hold", time_ns, t0);

    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom % 16;
      case (op)
        0: wr(3'd3, {17'd0, 7'($urandom), 1'b0, 7'($urandom)});
        1: wr(3'd4, ($urandom % 3 == 0) ? 32'($urandom % 2) : 32'($urandom % 9));
        2: wr(3'd2, ($urandom % 2) ? 32'h8000_0000 : 32'(200 + $urandom % 800));
        3: wr(3'd0, {24'd0, 1'($urandom), 4'd0, 1'($urandom), 1'($urandom),
                     ($urandom % 4 != 0)});
        4: wr(3'd1, ($urandom % 2) ? (m_per - 32'($urandom % 40)) : (32'hFFFF_FFF0 + 32'($urandom % 16)));
        5: begin rd("R9 rand", 3'($urandom % 6)); cyc(); end
        default: cyc();
      endcase
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule